// File: doc/BRIEF.md
# Packed 32-bit Min/Max/Abs Unit

This execution unit sits in the integer pipeline of a 64-bit core. It treats each 64-bit source operand as two independent 32-bit lanes and runs one of five packed operations on them: signed minimum, unsigned minimum, signed maximum, unsigned maximum, and a saturating absolute value. Each lane is worked out by itself and written back into the bit positions it came from.

The unit decodes the 32-bit instruction word itself. When the custom major opcode matches but none of the five encodings does, it raises an illegal indication in place of a result. A result appears one clock after the input is accepted. When a lane would overflow in the absolute-value operation, a sticky saturation flag is set. Only a dedicated synchronous clear input resets the flag, and a saturating operation in the same cycle as a clear takes priority over it.

Top module: `pk32_minmax_unit`

## Requirements
- R1: Lane 0 is bits [31:0] and lane 1 is bits [63:32] of each operand and of the result. Each lane result depends only on the same lane of the operands.
- R2: Major opcode insn[6:0]=1111111 with funct3 insn[14:12]=010 and funct7 insn[31:25]=1001000 returns the two's-complement minimum of each lane.
- R3: Opcode 1111111, funct3 010, funct7 1010000 returns the unsigned minimum of each lane.
- R4: Opcode 1111111, funct3 010, funct7 1001001 returns the two's-complement maximum of each lane.
- R5: Opcode 1111111, funct3 010, funct7 1010001 returns the unsigned maximum of each lane.
- R6: Opcode 1111111, funct3 000, funct7 1010110 with insn[24:20]=10010 returns the absolute value of each lane of src_a, with src_b ignored. A lane equal to 0x80000000 gives 0x7FFFFFFF.
- R7: sat_flag goes high one cycle after an accepted absolute-value operation in which at least one lane equals 0x80000000. It then stays high, and operations that do not saturate leave it unchanged.
- R8: flag_clr high at a clock edge clears sat_flag. If a saturating operation is accepted in that same cycle, the flag is set instead.
- R9: An accepted word with opcode 1111111 that matches none of the five encodings raises illegal for one cycle and leaves res_valid low. A word with any other opcode raises neither output.
- R10: res_valid and res_data follow an accepted legal input after exactly one clock. res_valid stays low in any cycle after in_valid was low.
- R11: While rst_n is low at a clock edge, res_valid, illegal and sat_flag are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_clr | input | 1 | Synchronous clear of the saturation flag |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 64 | First source operand (rs1) |
| src_b | input | 64 | Second source operand (rs2) |
| res_data | output | 64 | Packed lane results |
| res_valid | output | 1 | res_data holds a new result |
| illegal | output | 1 | Custom opcode with an unknown encoding was accepted |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Two flag actions can land in the same clock edge: a software clear through flag_clr, and a new saturation from an absolute-value operation on 0x80000000. The bench first sets the flag, clears it on its own, and then drives flag_clr high in the same cycle as a saturating absolute-value input. It checks that the flag reads high after that edge and that the lane still gives 0x7FFFFFFF. A later clear on its own must then bring the flag back to zero.

// File: rtl/pk32_pkg.sv
// Package: shared widths, opcode constants and the operation type for the
// packed 32-bit min/max/abs unit. Assumes a 64-bit datapath split into
// equal lanes.
package pk32_pkg;

    localparam int XLEN     = 64;
    localparam int LANE_W   = 32;
    localparam int N_LANES  = XLEN / LANE_W;
    localparam int INSN_W   = 32;

    localparam logic [6:0] OPC_PACKED   = 7'b1111111;
    localparam logic [2:0] F3_MINMAX    = 3'b010;
    localparam logic [2:0] F3_ABS       = 3'b000;
    localparam logic [6:0] F7_SMIN      = 7'b1001000;
    localparam logic [6:0] F7_UMIN      = 7'b1010000;
    localparam logic [6:0] F7_SMAX      = 7'b1001001;
    localparam logic [6:0] F7_UMAX      = 7'b1010001;
    localparam logic [6:0] F7_ABS       = 7'b1010110;
    localparam logic [4:0] RS2_ABS      = 5'b10010;

    typedef enum logic [2:0] {
        OP_SMIN = 3'd0,
        OP_UMIN = 3'd1,
        OP_SMAX = 3'd2,
        OP_UMAX = 3'd3,
        OP_ABS  = 3'd4,
        OP_NONE = 3'd7
    } pk_op_e;

endpackage

// File: rtl/pk32_decode.sv
// Module: pk32_decode
// Turns the instruction fields into one of the five packed operations.
// Assumes the R-type field layout; rd and rs1 are not needed here.
// major_hit flags the custom opcode; legal flags one of the known encodings.
module pk32_decode
    import pk32_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    input  logic [4:0] rs2_fld,
    output pk_op_e     op,
    output logic       major_hit,
    output logic       legal
);

    // Match the encodings of the five operations.
    always_comb begin
        major_hit = (opcode == OPC_PACKED);
        op        = OP_NONE;
        if (major_hit) begin
            if (funct3 == F3_MINMAX) begin
                unique case (funct7)
                    F7_SMIN: op = OP_SMIN;
                    F7_UMIN: op = OP_UMIN;
                    F7_SMAX: op = OP_SMAX;
                    F7_UMAX: op = OP_UMAX;
                    default: op = OP_NONE;
                endcase
            end else if (funct3 == F3_ABS && funct7 == F7_ABS && rs2_fld == RS2_ABS) begin
                op = OP_ABS;
            end
        end
        legal = (op != OP_NONE);
    end

endmodule

// File: rtl/pk32_lane.sv
// Module: pk32_lane
// One lane of the unit: signed/unsigned min and max, and an absolute value
// that clamps the most negative input to the most positive value.
// Assumes op is already decoded; b is ignored for the absolute value.
module pk32_lane
    import pk32_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  pk_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         sat
);

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] a_neg;

    // Both comparisons and the negation, shared by every operation.
    always_comb begin
        lt_s  = ($signed(a) < $signed(b));
        lt_u  = (a < b);
        a_neg = (~a) + {{(W-1){1'b0}}, 1'b1};
    end

    // Pick the lane result for the decoded operation.
    always_comb begin
        sat = 1'b0;
        unique case (op)
            OP_SMIN: y = lt_s ? a : b;
            OP_UMIN: y = lt_u ? a : b;
            OP_SMAX: y = lt_s ? b : a;
            OP_UMAX: y = lt_u ? b : a;
            OP_ABS: begin
                if (a == MOST_NEG) begin
                    y   = MOST_POS;
                    sat = 1'b1;
                end else begin
                    y = a[W-1] ? a_neg : a;
                end
            end
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pk32_flag.sv
// Module: pk32_flag
// Sticky saturation flag. Assumes set and clear are synchronous; a set in
// the same cycle as a clear wins so no saturation event is lost.
module pk32_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Hold, clear or set the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/pk32_minmax_unit.sv
// Module: pk32_minmax_unit (top)
// Packed two-lane min/max/abs execution unit with one register stage.
// Assumes in_valid marks a single-cycle issue; results are registered and
// held between operations; illegal pulses for custom-opcode words that
// match no known encoding.
module pk32_minmax_unit
    import pk32_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int LW     = LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_clr,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              illegal,
    output logic              sat_flag
);

    localparam int NL = DATA_W / LW;

    pk_op_e            op;
    logic              major_hit;
    logic              legal;
    logic [DATA_W-1:0] lane_y;
    logic [NL-1:0]     lane_sat;
    logic              sat_event;
    logic              unused_insn;

    assign unused_insn = ^insn[19:7];

    pk32_decode u_dec (
        .opcode    (insn[6:0]),
        .funct3    (insn[14:12]),
        .funct7    (insn[31:25]),
        .rs2_fld   (insn[24:20]),
        .op        (op),
        .major_hit (major_hit),
        .legal     (legal)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lane
        pk32_lane #(.W(LW)) u_lane (
            .op  (op),
            .a   (src_a[g*LW +: LW]),
            .b   (src_b[g*LW +: LW]),
            .y   (lane_y[g*LW +: LW]),
            .sat (lane_sat[g])
        );
    end

    // One flag event per accepted operation, whichever lanes saturated.
    always_comb begin
        sat_event = in_valid && legal && (|lane_sat);
    end

    // Register valid and illegal strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= in_valid && legal;
            illegal   <= in_valid && major_hit && !legal;
        end
    end

    // Capture the packed result of accepted legal operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (in_valid && legal) begin
            res_data <= lane_y;
        end
    end

    pk32_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sat_event),
        .clr_i  (flag_clr),
        .flag_o (sat_flag)
    );

endmodule

// File: rtl/pk32_minmax_chk.sv
// Module: pk32_minmax_chk
// Protocol and flag assertions for pk32_minmax_unit, bound to the top.
// Assumes the top's default 64-bit, two-lane configuration.
module pk32_minmax_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flag_clr,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic [63:0] res_data,
    input logic        res_valid,
    input logic        illegal,
    input logic        sat_flag
);

    // R9: a result and an illegal indication never appear together.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && illegal));

    // R9: illegal only follows an accepted word with the custom opcode.
    a_r9_illegal_src: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(in_valid) && $past(insn[6:0]) == 7'b1111111));

    // R10: no result without an accepted input one cycle earlier.
    a_r10_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));

    // R7: the flag only rises after an absolute-value issue.
    a_r7_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> ($past(in_valid) && $past(insn[31:25]) == 7'b1010110));

    // R7/R8: without a clear the flag stays set.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !flag_clr) |=> sat_flag);

    // R6: an absolute-value result never contains the most negative lane.
    a_r6_no_min_out: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(insn[31:25]) == 7'b1010110) |->
        (res_data[63:32] != 32'h80000000 && res_data[31:0] != 32'h80000000));

endmodule

bind pk32_minmax_unit pk32_minmax_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_clr  (flag_clr),
    .in_valid  (in_valid),
    .insn      (insn),
    .res_data  (res_data),
    .res_valid (res_valid),
    .illegal   (illegal),
    .sat_flag  (sat_flag)
);

// File: tb/pk32_minmax_unit_tb.sv
`timescale 1ns/1ps
module pk32_minmax_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] res_data;
    logic        res_valid;
    logic        illegal;
    logic        sat_flag;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pk32_minmax_unit u_dut (
        .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .in_valid(in_valid),
        .insn(insn), .src_a(src_a), .src_b(src_b), .res_data(res_data),
        .res_valid(res_valid), .illegal(illegal), .sat_flag(sat_flag)
    );

    // Instruction builder: funct7, rs2 field, funct3, opcode; rs1=1, rd=3.
    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                       input logic [2:0] f3, input logic [6:0] opc);
        return {f7, r2, 5'd1, f3, 5'd3, opc};
    endfunction

    localparam logic [31:0] I_SMIN = {7'b1001000, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1111111};
    localparam logic [31:0] I_UMIN = {7'b1010000, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1111111};
    localparam logic [31:0] I_SMAX = {7'b1001001, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1111111};
    localparam logic [31:0] I_UMAX = {7'b1010001, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1111111};
    localparam logic [31:0] I_ABS  = {7'b1010110, 5'b10010, 5'd1, 3'b000, 5'd3, 7'b1111111};

    typedef struct packed {
        logic [31:0] ins;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{I_SMIN, 64'h80000000_00000005, 64'h7FFFFFFF_FFFFFFFF, 64'h80000000_FFFFFFFF},
        '{I_UMIN, 64'h80000000_00000005, 64'h7FFFFFFF_FFFFFFFF, 64'h7FFFFFFF_00000005},
        '{I_SMAX, 64'h80000000_00000005, 64'h7FFFFFFF_FFFFFFFF, 64'h7FFFFFFF_00000005},
        '{I_UMAX, 64'h80000000_00000005, 64'h7FFFFFFF_FFFFFFFF, 64'h80000000_FFFFFFFF},
        '{I_SMIN, 64'h12345678_FFFFFFFE, 64'h12345678_FFFFFFFD, 64'h12345678_FFFFFFFD},
        '{I_UMAX, 64'h00000001_00000000, 64'h00000000_00000001, 64'h00000001_00000001},
        '{I_ABS,  64'hFFFFFFFF_00000007, 64'hDEADBEEF_80000000, 64'h00000001_00000007},
        '{I_ABS,  64'hFFFFFF9C_7FFFFFFF, 64'h80000000_80000000, 64'h00000064_7FFFFFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation at a negedge and move to the next negedge.
    task automatic issue(input logic [31:0] i, input logic [63:0] a,
                         input logic [63:0] b, input logic clr);
        insn = i; src_a = a; src_b = b; in_valid = 1'b1; flag_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic idle(input logic clr);
        in_valid = 1'b0; flag_clr = clr;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        #4000000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset valid", {63'd0, res_valid}, 64'd0);
        chk("R11 reset illegal", {63'd0, illegal}, 64'd0);
        chk("R11 reset flag", {63'd0, sat_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R10: vector table
        for (int k = 0; k < NV; k++) begin
            issue(VEC[k].ins, VEC[k].a, VEC[k].b, 1'b0);
            chk($sformatf("R1/R2-R6 vec%0d data", k), res_data, VEC[k].exp);
            chk($sformatf("R10 vec%0d valid", k), {63'd0, res_valid}, 64'd1);
            chk($sformatf("R7 vec%0d flag unchanged", k), {63'd0, sat_flag}, 64'd0);
        end

        // R10: no result in a cycle after in_valid low
        idle(1'b0);
        chk("R10 idle valid", {63'd0, res_valid}, 64'd0);

        // R6 R7: most negative low lane saturates
        issue(I_ABS, 64'h00000003_80000000, 64'h0, 1'b0);
        chk("R6 sat lane data", res_data, 64'h00000003_7FFFFFFF);
        chk("R7 flag set", {63'd0, sat_flag}, 64'd1);

        // R1 R6: both lanes saturate
        issue(I_ABS, 64'h80000000_80000000, 64'h0, 1'b0);
        chk("R1 both lanes sat", res_data, 64'h7FFFFFFF_7FFFFFFF);

        // R7: non-saturating op leaves flag set
        issue(I_UMIN, 64'h00000004_00000009, 64'h00000006_00000002, 1'b0);
        chk("R3 umin data", res_data, 64'h00000004_00000002);
        chk("R7 flag sticky", {63'd0, sat_flag}, 64'd1);

        // R8: clear alone
        idle(1'b1);
        chk("R8 clear", {63'd0, sat_flag}, 64'd0);

        // R8: clear and saturation in the same cycle; set wins
        issue(I_ABS, 64'h80000000_00000001, 64'h0, 1'b1);
        chk("R8 set beats clear", {63'd0, sat_flag}, 64'd1);
        chk("R8 same-cycle data", res_data, 64'h7FFFFFFF_00000001);
        idle(1'b1);
        chk("R8 clear after", {63'd0, sat_flag}, 64'd0);

        // R9: unknown funct7 under the custom opcode
        issue(mk(7'b1111111, 5'd2, 3'b010, 7'b1111111), 64'h1, 64'h2, 1'b0);
        chk("R9 illegal funct7", {62'd0, illegal, res_valid}, 64'd2);
        // R9 R6: abs with wrong rs2 field
        issue(mk(7'b1010110, 5'b00000, 3'b000, 7'b1111111), 64'h80000000_80000000, 64'h0, 1'b0);
        chk("R9 illegal abs rs2", {62'd0, illegal, res_valid}, 64'd2);
        chk("R9 no flag from illegal", {63'd0, sat_flag}, 64'd0);
        // R9: min with wrong funct3
        issue(mk(7'b1001000, 5'd2, 3'b000, 7'b1111111), 64'h1, 64'h2, 1'b0);
        chk("R9 illegal funct3", {62'd0, illegal, res_valid}, 64'd2);
        // R9: foreign opcode raises nothing
        issue(mk(7'b1001000, 5'd2, 3'b010, 7'b0110011), 64'h1, 64'h2, 1'b0);
        chk("R9 foreign opcode", {62'd0, illegal, res_valid}, 64'd0);
        idle(1'b0);
        chk("R9 illegal one cycle", {63'd0, illegal}, 64'd0);

        // R11: reset mid-run clears flag and valid
        issue(I_ABS, 64'h80000000_00000000, 64'h0, 1'b0);
        chk("R7 flag before reset", {63'd0, sat_flag}, 64'd1);
        rst_n = 1'b0;
        issue(I_SMAX, 64'h1, 64'h2, 1'b0);
        chk("R11 reset valid mid", {63'd0, res_valid}, 64'd0);
        chk("R11 reset flag mid", {63'd0, sat_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule